// File: doc/BRIEF.md
# Pipeline Stall and Freeze Sequencer

This block sequences the pipeline registers of a six-stage, four-lane in-order wide-issue core. The stages, in order, are fetch, decode, register read, execute, memory and write-back. Each stage holds one bundle of up to four lane slots. The block does not touch any operation data. It drives a payload-load enable for every stage, a bundle-valid bit for every stage, a per-slot valid bit and a bubble flag that marks a stage emptied by an instruction-cache miss.

The block handles two cache events in different ways. A data-cache miss, raised by the memory stage, holds the whole pipe for every cycle it is asserted. No enable rises and no valid, slot or bubble bit changes. An instruction-cache miss request starts a fill that lasts `IMISS_CYC` unstalled cycles. During the fill the fetch register is frozen rather than loaded with a no-op. Its valid bit is cleared and its bubble flag is set, so empty, non-toggling bubbles move down while the younger bundles drain. A data miss has priority over a fill and pauses its countdown. Two counters record data-stall cycles and fill (freeze) cycles, and they can be cleared synchronously.

A control FSM has four states:
- `S_RUN`: normal flow.
- `S_DHOLD`: data stall with no fill pending.
- `S_IFILL`: fill in progress.
- `S_IPAUSE`: fill paused by a data stall.

Its transitions are:
- `S_RUN`/`S_DHOLD` go to `S_IFILL` on a request without a data miss, or to `S_IPAUSE` on a request with a data miss.
- Without a request, they go to `S_DHOLD` while the data miss is high, else to `S_RUN`.
- `S_IFILL`/`S_IPAUSE` go to `S_IPAUSE` while the data miss is high.
- Otherwise they go back to `S_RUN` on the last freeze cycle, or to `S_IFILL` to continue.

Top module: `pl_stall_ctrl`

## Requirements
- R1: With no data miss and no freeze, `stage_en[0]` is 1 exactly when `if_bundle_vld` is 1, and `stage_en[i]` (i≥1) is 1 exactly when `stage_vld[i-1]` is 1. Enables are combinational in the current cycle.
- R2: While `dc_miss` is 1, every bit of `stage_en` is 0. After that edge, `stage_vld`, `slot_vld` and `stage_bub` keep their previous values.
- R3: On an unstalled, unfrozen edge, fetch loads valid = `if_bundle_vld` and slot bits = `if_slot_mask` (bit k = lane k) when valid, else zero. Slot bits for stage s sit at `slot_vld[s*4 +: 4]`. Every stage s≥1 takes stage s-1's valid, slot and bubble bits.
- R4: An `ic_miss_req` accepted while no fill is active makes the next `IMISS_CYC` unstalled cycles freeze cycles. In a freeze cycle `stage_en[0]` is 0, and at its edge fetch gets valid 0, slot bits 0 and bubble 1. Bubbles advance like bundles.
- R5: `ic_miss_req` is ignored while a fill is active, whether it is running or paused.
- R6: A cycle with `dc_miss` high is never a freeze cycle and does not use up fill cycles. A request in the same cycle as a data miss is still accepted.
- R7: After reset every valid, slot and bubble bit and both counters are 0.
- R8: `dstall_cnt` rises by one for each cycle with `dc_miss` high. `imiss_cnt` rises by one for each freeze cycle.
- R9: `cnt_clr` makes both counters 0 at the next edge, with priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_bundle_vld | input | 1 | A bundle is offered to fetch |
| if_slot_mask | input | 4 | Occupied lanes of the offered bundle |
| ic_miss_req | input | 1 | Instruction-cache miss starts a fill |
| dc_miss | input | 1 | Data-cache miss pending in the memory stage |
| cnt_clr | input | 1 | Synchronous counter clear |
| stage_en | output | 6 | Payload-load enable per stage |
| stage_vld | output | 6 | Bundle valid per stage |
| slot_vld | output | 24 | Lane slot valids, 4 per stage |
| stage_bub | output | 6 | Stage holds a fill bubble |
| dstall_cnt | output | 32 | Data-stall cycle count |
| imiss_cnt | output | 32 | Freeze cycle count |

## Verification
A data miss and a running or starting fill can land in the same cycle, and the priority between them is the riskiest behaviour. The bench raises `dc_miss` together with a fresh `ic_miss_req`, and raises it again in the middle of a fill, in directed runs and in a long random mix. Each cycle it compares enables, bubbles and both counters against a behavioural model. In that model a stalled cycle neither freezes fetch nor consumes fill time, and the request is still accepted.

// File: rtl/pl_ctrl_pkg.sv
package pl_ctrl_pkg;
    typedef enum logic [1:0] {
        S_RUN    = 2'd0,
        S_DHOLD  = 2'd1,
        S_IFILL  = 2'd2,
        S_IPAUSE = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/pl_miss_fsm.sv
module pl_miss_fsm
    import pl_ctrl_pkg::*;
#(
    parameter int IMISS_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ic_miss_req,
    input  logic dc_miss,
    output logic hold,
    output logic freeze
);
    localparam int RW = $clog2(IMISS_CYC + 1);
    localparam logic [RW-1:0] LOAD = RW'(IMISS_CYC);
    localparam logic [RW-1:0] ONE  = RW'(1);

    ctl_state_e state, nxt;
    logic [RW-1:0] remain;
    logic          fill_on;
    logic          accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_RUN, S_DHOLD: begin
                if (ic_miss_req) nxt = dc_miss ? S_IPAUSE : S_IFILL;
                else             nxt = dc_miss ? S_DHOLD  : S_RUN;
            end
            S_IFILL, S_IPAUSE: begin
                if (dc_miss)            nxt = S_IPAUSE;
                else if (remain == ONE) nxt = S_RUN;
                else                    nxt = S_IFILL;
            end
            default: nxt = S_RUN;
        endcase
    end

    always_comb begin
        fill_on = (state == S_IFILL) || (state == S_IPAUSE);
        hold    = dc_miss;
        freeze  = fill_on && !dc_miss;
        accept  = !fill_on && ic_miss_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      remain <= '0;
        else if (accept) remain <= LOAD;
        else if (freeze) remain <= remain - ONE;
    end
endmodule

// File: rtl/pl_stage_track.sv
module pl_stage_track #(
    parameter int STAGES = 6,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hold,
    input  logic                      freeze,
    input  logic                      if_vld,
    input  logic [LANES-1:0]          if_mask,
    output logic [STAGES-1:0]         stage_en,
    output logic [STAGES-1:0]         stage_vld,
    output logic [STAGES*LANES-1:0]   slot_vld,
    output logic [STAGES-1:0]         stage_bub
);
    logic [LANES-1:0] slots [STAGES];

    always_comb stage_en[0] = !hold && !freeze && if_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_vld[0] <= 1'b0;
            slots[0]     <= '0;
            stage_bub[0] <= 1'b0;
        end else if (!hold) begin
            if (freeze) begin
                stage_vld[0] <= 1'b0;
                slots[0]     <= '0;
                stage_bub[0] <= 1'b1;
            end else begin
                stage_vld[0] <= if_vld;
                slots[0]     <= if_vld ? if_mask : '0;
                stage_bub[0] <= 1'b0;
            end
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb stage_en[s] = !hold && stage_vld[s-1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_vld[s] <= 1'b0;
                slots[s]     <= '0;
                stage_bub[s] <= 1'b0;
            end else if (!hold) begin
                stage_vld[s] <= stage_vld[s-1];
                slots[s]     <= slots[s-1];
                stage_bub[s] <= stage_bub[s-1];
            end
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_flat
        assign slot_vld[s*LANES +: LANES] = slots[s];
    end
endmodule

// File: rtl/pl_evt_cnt.sv
module pl_evt_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/pl_stall_ctrl.sv
module pl_stall_ctrl #(
    parameter int STAGES    = 6,
    parameter int LANES     = 4,
    parameter int IMISS_CYC = 4,
    parameter int CNT_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    if_bundle_vld,
    input  logic [LANES-1:0]        if_slot_mask,
    input  logic                    ic_miss_req,
    input  logic                    dc_miss,
    input  logic                    cnt_clr,
    output logic [STAGES-1:0]       stage_en,
    output logic [STAGES-1:0]       stage_vld,
    output logic [STAGES*LANES-1:0] slot_vld,
    output logic [STAGES-1:0]       stage_bub,
    output logic [CNT_W-1:0]        dstall_cnt,
    output logic [CNT_W-1:0]        imiss_cnt
);
    logic hold;
    logic freeze;

    pl_miss_fsm #(.IMISS_CYC(IMISS_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ic_miss_req(ic_miss_req),
        .dc_miss(dc_miss), .hold(hold), .freeze(freeze)
    );

    pl_stage_track #(.STAGES(STAGES), .LANES(LANES)) u_track (
        .clk(clk), .rst_n(rst_n), .hold(hold), .freeze(freeze),
        .if_vld(if_bundle_vld), .if_mask(if_slot_mask),
        .stage_en(stage_en), .stage_vld(stage_vld),
        .slot_vld(slot_vld), .stage_bub(stage_bub)
    );

    pl_evt_cnt #(.W(CNT_W)) u_dcnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(hold), .count(dstall_cnt)
    );

    pl_evt_cnt #(.W(CNT_W)) u_icnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(freeze), .count(imiss_cnt)
    );
endmodule

// File: rtl/pl_stall_ctrl_chk.sv
module pl_stall_ctrl_chk #(
    parameter int STAGES = 6,
    parameter int LANES  = 4,
    parameter int CNT_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    dc_miss,
    input logic                    cnt_clr,
    input logic [STAGES-1:0]       stage_en,
    input logic [STAGES-1:0]       stage_vld,
    input logic [STAGES*LANES-1:0] slot_vld,
    input logic [STAGES-1:0]       stage_bub,
    input logic [CNT_W-1:0]        dstall_cnt,
    input logic [CNT_W-1:0]        imiss_cnt
);
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        dc_miss |-> stage_en == '0); // R2

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        dc_miss |=> (slot_vld == $past(slot_vld)) && (stage_vld == $past(stage_vld))
                    && (stage_bub == $past(stage_bub))); // R2

    AST_BUB_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !dc_miss |=> stage_bub[STAGES-1:1] == $past(stage_bub[STAGES-2:0])); // R4

    AST_BUB_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        stage_bub[0] |-> !stage_vld[0]); // R4

    AST_BUB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_bub[0]) |-> !$past(stage_en[0])); // R4

    AST_DCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_miss && !cnt_clr) |=> dstall_cnt == $past(dstall_cnt) + CNT_W'(1)); // R8

    AST_IMISS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_miss && !cnt_clr) |=> imiss_cnt == $past(imiss_cnt)); // R6

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (dstall_cnt == '0) && (imiss_cnt == '0)); // R9
endmodule

bind pl_stall_ctrl pl_stall_ctrl_chk #(.STAGES(STAGES), .LANES(LANES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dc_miss(dc_miss), .cnt_clr(cnt_clr),
    .stage_en(stage_en), .stage_vld(stage_vld), .slot_vld(slot_vld),
    .stage_bub(stage_bub), .dstall_cnt(dstall_cnt), .imiss_cnt(imiss_cnt)
);

// File: tb/sim_pl_stall_ctrl.sv
`timescale 1ns/1ps
module sim_pl_stall_ctrl;
    localparam int ST = 6;
    localparam int LN = 4;
    localparam int MISS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_bundle_vld = 1'b0;
    logic [LN-1:0] if_slot_mask = '0;
    logic ic_miss_req = 1'b0;
    logic dc_miss = 1'b0;
    logic cnt_clr = 1'b0;
    logic [ST-1:0] stage_en, stage_vld, stage_bub;
    logic [ST*LN-1:0] slot_vld;
    logic [31:0] dstall_cnt, imiss_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    bit m_vld [ST];
    bit m_bub [ST];
    int m_slot [ST];
    bit fill_on = 0;
    int rem = 0;
    int m_dcnt = 0;
    int m_icnt = 0;

    always #10 clk = ~clk;

    pl_stall_ctrl #(.STAGES(ST), .LANES(LN), .IMISS_CYC(MISS), .CNT_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .if_bundle_vld(if_bundle_vld),
        .if_slot_mask(if_slot_mask), .ic_miss_req(ic_miss_req),
        .dc_miss(dc_miss), .cnt_clr(cnt_clr), .stage_en(stage_en),
        .stage_vld(stage_vld), .slot_vld(slot_vld), .stage_bub(stage_bub),
        .dstall_cnt(dstall_cnt), .imiss_cnt(imiss_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit dc, input bit req, input bit iv, input int mask, input bit clr);
        bit frz;
        logic [ST-1:0] e_en, e_vld, e_bub;
        logic [ST*LN-1:0] e_slot;
        @(negedge clk);
        dc_miss = dc; ic_miss_req = req; if_bundle_vld = iv;
        if_slot_mask = LN'(mask); cnt_clr = clr;
        #1;
        frz = fill_on && !dc;
        e_en[0] = !dc && !frz && iv;
        for (int s = 0; s < ST; s++) begin
            if (s > 0) e_en[s] = !dc && m_vld[s-1];
            e_vld[s] = m_vld[s];
            e_bub[s] = m_bub[s];
            e_slot[s*LN +: LN] = LN'(m_slot[s]);
        end
        chk(dc ? "R2 enables" : (frz ? "R4 enables" : "R1 enables"), 32'(stage_en), 32'(e_en));
        chk("R3 stage valid", 32'(stage_vld), 32'(e_vld));
        chk("R3 slot valid", 32'(slot_vld), 32'(e_slot));
        chk("R4 bubble", 32'(stage_bub), 32'(e_bub));
        chk("R8 dstall count", dstall_cnt, 32'(m_dcnt));
        chk("R6 imiss count", imiss_cnt, 32'(m_icnt));
        // advance model for this edge
        if (!dc) begin
            for (int s = ST - 1; s > 0; s--) begin
                m_vld[s] = m_vld[s-1]; m_bub[s] = m_bub[s-1]; m_slot[s] = m_slot[s-1];
            end
            if (frz) begin
                m_vld[0] = 0; m_bub[0] = 1; m_slot[0] = 0;
            end else begin
                m_vld[0] = iv; m_bub[0] = 0; m_slot[0] = iv ? mask : 0;
            end
        end
        if (clr) begin
            m_dcnt = 0; m_icnt = 0;
        end else begin
            if (dc) m_dcnt++;
            if (frz) m_icnt++;
        end
        if (fill_on) begin
            if (frz) begin
                rem--;
                if (rem == 0) fill_on = 0;
            end
        end else if (req) begin
            fill_on = 1; rem = MISS;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < ST; s++) begin
            m_vld[s] = 0; m_bub[s] = 0; m_slot[s] = 0;
        end
        #45;
        // R7: reset state
        chk("R7 reset valid", 32'(stage_vld), 32'd0);
        chk("R7 reset slots", 32'(slot_vld), 32'd0);
        chk("R7 reset bubble", 32'(stage_bub), 32'd0);
        chk("R7 reset dcnt", dstall_cnt, 32'd0);
        chk("R7 reset icnt", imiss_cnt, 32'd0);
        rst_n = 1'b1;
        // R1/R3: plain flow with varied masks
        for (int i = 0; i < 10; i++) cyc(0, 0, (i % 3) != 2, (i * 5 + 1) & 15, 0);
        // R4: lone fill, then R5 requests ignored while active
        cyc(0, 1, 1, 15, 0);
        cyc(0, 1, 1, 3, 0);
        cyc(0, 1, 1, 9, 0);
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, 6, 0);
        // R2: data stall alone
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 12, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 5, 0);
        // R6: simultaneous request and data miss
        cyc(1, 1, 1, 15, 0);
        cyc(1, 0, 1, 15, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 7, 0);
        // R6: data miss in the middle of a fill
        cyc(0, 1, 1, 2, 0);
        cyc(0, 0, 1, 2, 0);
        cyc(1, 1, 1, 2, 0);
        cyc(1, 0, 1, 2, 0);
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, 4, 0);
        // R9: clear during counting
        cyc(1, 0, 1, 1, 1);
        cyc(0, 0, 1, 1, 0);
        // random mix
        for (int i = 0; i < 3000; i++)
            cyc(($urandom % 5) == 0, ($urandom % 9) == 0, ($urandom % 4) != 0,
                int'($urandom % 16), ($urandom % 97) == 0);
        cyc(0, 0, 0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule